// File: doc/BRIEF.md
# Serial Program Loader with Byte Echo

This block fills a 24-bit program memory from an asynchronous serial line during start-up. A receiver and a transmitter in 8N1 format (eight data bits, no parity, one stop bit) are timed by a strobe that pulses sixteen times per bit period. The host first sends a three-byte word count and then a three-byte load address. After that it sends the program, three bytes per word. Every multi-byte value arrives low byte first, then the middle byte, then the high byte.

Each byte that the loader accepts is sent back on the transmit line, so the host can check the link. Once the last word has been written, the block raises a run flag and presents the load address as the place where execution begins. The block acts only when the three mode inputs select the serial load. The other codes, including the reserved code next to it, leave it idle.

Top module: `serial_boot_loader`

## Requirements
- R1: The loader acts only when `boot_mode` equals 3'b110. For any other code, including the reserved 3'b111, received bytes produce no echo, no memory write and no run flag.
- R2: A byte is received as an 8N1 frame. Data bits arrive least significant bit first, and each bit is sampled on the 8th `os_tick` of its 16-tick period.
- R3: A start bit that is high again at its midpoint is rejected. No byte results from it, and the next valid frame is received normally.
- R4: A frame whose stop bit is low sets `frame_err`, which stays set until reset. That byte is discarded: it is not echoed and does not count toward any field.
- R5: Every accepted byte is retransmitted on `txd` as an 8N1 frame, in arrival order. `txd` rests high when idle.
- R6: The first three accepted bytes form the word count and the next three form the start address, each low byte first.
- R7: Each later group of three bytes (low, middle, high) forms one 24-bit word. Words are written with a single `ram_we` pulse each, to consecutive addresses starting at the start address.
- R8: When the last word is written, `run` rises and stays high, and `run_addr` equals the start address. Bytes received after that are neither echoed nor written.
- R9: A word count of zero raises `run` right after the address header, with no memory write.
- R10: After reset, `txd` is high, and `run`, `frame_err` and `ram_we` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| os_tick | input | 1 | One-cycle strobe at 16x the baud rate |
| boot_mode | input | 3 | Start-up mode code; 3'b110 selects the serial load |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line (echo) |
| ram_we | output | 1 | Program memory write strobe |
| ram_addr | output | ADDR_W | Program memory write address |
| ram_wdata | output | WORD_W | Program memory write data |
| run | output | 1 | Load finished; execution may start |
| run_addr | output | WORD_W | Address where execution starts |
| frame_err | output | 1 | Sticky flag: a stop bit was low |

## Verification
The assertions check on every cycle that:
- a received byte strobe lasts one cycle;
- each transmitted frame begins with a low start bit;
- no write happens while the mode is off or after `run` is set;
- `run` never falls once raised.

Only the bench scenarios can show the rest:
- the byte order within each header and word field;
- the addresses and data actually written;
- the echoed byte values and their order;
- the rejection of a short start pulse;
- the handling of a zero word count and of the reserved mode.

// File: rtl/sboot_pkg.sv
package sboot_pkg;
    typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_e;
    typedef enum logic [1:0] {LD_HDR, LD_DATA, LD_RUN} ld_state_e;
endpackage

// File: rtl/sboot_uart_rx.sv
module sboot_uart_rx
    import sboot_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       rxd,
    output logic       byte_vld,
    output logic [7:0] byte_data,
    output logic       byte_err
);
    localparam int CW = $clog2(OVS);
    localparam logic [CW-1:0] MID  = CW'(OVS / 2 - 1);
    localparam logic [CW-1:0] LAST = CW'(OVS - 1);

    typedef struct packed {
        logic      s1;
        logic      s2;
        rx_state_e st;
        logic [CW-1:0] cnt;
        logic [2:0] bitn;
        logic [7:0] sh;
        logic      vld;
        logic      err;
    } rx_t;

    rx_t q, d;

    always_comb begin
        d     = q;
        d.vld = 1'b0;
        d.err = 1'b0;
        d.s1  = rxd;
        d.s2  = q.s1;
        if (tick) begin
            case (q.st)
                RX_IDLE: if (!q.s2) begin
                    d.st  = RX_START;
                    d.cnt = '0;
                end
                RX_START: if (q.cnt == MID) begin
                    d.cnt  = '0;
                    d.bitn = '0;
                    d.st   = q.s2 ? RX_IDLE : RX_DATA;
                end else d.cnt = q.cnt + 1'b1;
                RX_DATA: if (q.cnt == LAST) begin
                    d.cnt  = '0;
                    d.sh   = {q.s2, q.sh[7:1]};
                    d.bitn = q.bitn + 1'b1;
                    if (q.bitn == 3'd7) d.st = RX_STOP;
                end else d.cnt = q.cnt + 1'b1;
                default: if (q.cnt == LAST) begin
                    d.cnt = '0;
                    d.st  = RX_IDLE;
                    if (q.s2) d.vld = 1'b1;
                    else      d.err = 1'b1;
                end else d.cnt = q.cnt + 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q    <= '0;
            q.s1 <= 1'b1;
            q.s2 <= 1'b1;
            q.st <= RX_IDLE;
        end else begin
            q <= d;
        end
    end

    assign byte_vld  = q.vld;
    assign byte_err  = q.err;
    assign byte_data = q.sh;

    a_r2_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        byte_vld |=> !byte_vld);
endmodule

// File: rtl/sboot_uart_tx.sv
module sboot_uart_tx #(
    parameter int OVS = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       wr,
    input  logic [7:0] wdata,
    output logic       empty,
    output logic       txd
);
    localparam int CW = $clog2(OVS);
    localparam logic [CW-1:0] LAST = CW'(OVS - 1);

    typedef struct packed {
        logic       full;
        logic [7:0] hold;
        logic       busy;
        logic [9:0] sh;
        logic [CW-1:0] cnt;
        logic [3:0] bitn;
    } tx_t;

    tx_t q, d;

    always_comb begin
        d = q;
        if (q.busy && tick) begin
            if (q.cnt == LAST) begin
                d.cnt  = '0;
                d.sh   = {1'b1, q.sh[9:1]};
                d.bitn = q.bitn + 1'b1;
                if (q.bitn == 4'd9) d.busy = 1'b0;
            end else d.cnt = q.cnt + 1'b1;
        end
        if (!q.busy && q.full) begin
            d.busy = 1'b1;
            d.sh   = {1'b1, q.hold, 1'b0};
            d.cnt  = '0;
            d.bitn = '0;
            d.full = 1'b0;
        end
        if (wr && !q.full) begin
            d.full = 1'b1;
            d.hold = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign empty = !q.full;
    assign txd   = q.busy ? q.sh[0] : 1'b1;

    a_r5_frame_starts_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.busy) |-> !txd);
endmodule

// File: rtl/sboot_loader_fsm.sv
module sboot_loader_fsm
    import sboot_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int WORD_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              rx_vld,
    input  logic [7:0]        rx_byte,
    input  logic              rx_err,
    input  logic              tx_empty,
    output logic              tx_wr,
    output logic [7:0]        tx_byte,
    output logic              ram_we,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [WORD_W-1:0] ram_wdata,
    output logic              run,
    output logic [WORD_W-1:0] run_addr,
    output logic              frame_err
);
    localparam int NB = WORD_W / 8;
    localparam int IW = (NB > 1) ? $clog2(NB) : 1;
    localparam logic [IW-1:0] LASTB = IW'(NB - 1);

    typedef struct packed {
        ld_state_e st;
        logic [IW-1:0] idx;
        logic      addr_phase;
        logic [WORD_W-1:0] asm_w;
        logic [WORD_W-1:0] cnt;
        logic [WORD_W-1:0] base;
        logic [WORD_W-1:0] ptr;
        logic      pend;
        logic [7:0] echo;
        logic      we;
        logic [ADDR_W-1:0] waddr;
        logic [WORD_W-1:0] wdata;
        logic      ferr;
    } ld_t;

    ld_t q, d;
    logic [WORD_W-1:0] word;

    always_comb begin
        d     = q;
        d.we  = 1'b0;
        word  = {rx_byte, q.asm_w[WORD_W-1:8]};
        tx_wr = q.pend && tx_empty;
        if (tx_wr) d.pend = 1'b0;
        if (rx_err) d.ferr = 1'b1;
        if (rx_vld && en && q.st != LD_RUN) begin
            d.pend  = 1'b1;
            d.echo  = rx_byte;
            d.asm_w = word;
            if (q.idx == LASTB) begin
                d.idx = '0;
                if (q.st == LD_HDR) begin
                    if (!q.addr_phase) begin
                        d.cnt        = word;
                        d.addr_phase = 1'b1;
                    end else begin
                        d.base = word;
                        d.ptr  = word;
                        d.st   = (q.cnt == '0) ? LD_RUN : LD_DATA;
                    end
                end else begin
                    d.we    = 1'b1;
                    d.waddr = q.ptr[ADDR_W-1:0];
                    d.wdata = word;
                    d.ptr   = q.ptr + 1'b1;
                    d.cnt   = q.cnt - 1'b1;
                    if (q.cnt == WORD_W'(1)) d.st = LD_RUN;
                end
            end else begin
                d.idx = q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= LD_HDR;
        end else begin
            q <= d;
        end
    end

    assign tx_byte   = q.echo;
    assign ram_we    = q.we;
    assign ram_addr  = q.waddr;
    assign ram_wdata = q.wdata;
    assign run       = (q.st == LD_RUN);
    assign run_addr  = q.base;
    assign frame_err = q.ferr;

    a_r1_no_write_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(en) |-> !ram_we);
    a_r8_run_holds: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> run);
    a_r8_no_write_after_run: assert property (@(posedge clk) disable iff (!rst_n)
        $past(run) |-> !ram_we);
    a_r4_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |=> frame_err);
endmodule

// File: rtl/serial_boot_loader.sv
module serial_boot_loader #(
    parameter int ADDR_W = 16,
    parameter int WORD_W = 24,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              os_tick,
    input  logic [2:0]        boot_mode,
    input  logic              rxd,
    output logic              txd,
    output logic              ram_we,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [WORD_W-1:0] ram_wdata,
    output logic              run,
    output logic [WORD_W-1:0] run_addr,
    output logic              frame_err
);
    localparam logic [2:0] MODE_SERIAL = 3'b110;

    logic       en;
    logic       rx_vld, rx_err, tx_wr, tx_empty;
    logic [7:0] rx_byte, tx_byte;

    assign en = (boot_mode == MODE_SERIAL);

    sboot_uart_rx #(.OVS(OVS)) u_rx (
        .clk(clk), .rst_n(rst_n), .tick(os_tick), .rxd(rxd),
        .byte_vld(rx_vld), .byte_data(rx_byte), .byte_err(rx_err)
    );

    sboot_uart_tx #(.OVS(OVS)) u_tx (
        .clk(clk), .rst_n(rst_n), .tick(os_tick), .wr(tx_wr),
        .wdata(tx_byte), .empty(tx_empty), .txd(txd)
    );

    sboot_loader_fsm #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .en(en),
        .rx_vld(rx_vld), .rx_byte(rx_byte), .rx_err(rx_err),
        .tx_empty(tx_empty), .tx_wr(tx_wr), .tx_byte(tx_byte),
        .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
        .run(run), .run_addr(run_addr), .frame_err(frame_err)
    );
endmodule

// File: tb/serial_boot_loader_tb.sv
module serial_boot_loader_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        os_tick = 1'b0;
    logic [2:0]  boot_mode = 3'b110;
    logic        rxd = 1'b1;
    logic        txd, ram_we, run, frame_err;
    logic [15:0] ram_addr;
    logic [23:0] ram_wdata, run_addr;

    int total = 0;
    int failed = 0;
    int div = 0;

    logic [7:0]  e_log [0:31];
    int          e_n = 0;
    logic [15:0] w_addr [0:15];
    logic [23:0] w_data [0:15];
    int          w_n = 0;

    int          m_st = 0;
    int          m_cnt = 0;
    int          m_bit = 0;
    logic [7:0]  m_sh = 8'h00;

    serial_boot_loader u_dut (
        .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .boot_mode(boot_mode),
        .rxd(rxd), .txd(txd), .ram_we(ram_we), .ram_addr(ram_addr),
        .ram_wdata(ram_wdata), .run(run), .run_addr(run_addr), .frame_err(frame_err)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        div     <= (div == 3) ? 0 : div + 1;
        os_tick <= (div == 3);
    end

    always @(posedge clk) begin
        if (ram_we && w_n < 16) begin
            w_addr[w_n] = ram_addr;
            w_data[w_n] = ram_wdata;
            w_n = w_n + 1;
        end
    end

    // echo line decoder: 8N1, sample mid-bit
    always @(posedge clk) begin
        if (os_tick) begin
            case (m_st)
                0: if (!txd) begin m_st = 1; m_cnt = 0; end
                1: if (m_cnt == 7) begin m_cnt = 0; m_bit = 0; m_st = txd ? 0 : 2; end
                   else m_cnt = m_cnt + 1;
                2: if (m_cnt == 15) begin
                       m_cnt = 0; m_sh = {txd, m_sh[7:1]}; m_bit = m_bit + 1;
                       if (m_bit == 8) m_st = 3;
                   end else m_cnt = m_cnt + 1;
                default: if (m_cnt == 15) begin
                       m_st = 0;
                       if (txd && e_n < 32) begin e_log[e_n] = m_sh; e_n = e_n + 1; end
                   end else m_cnt = m_cnt + 1;
            endcase
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            failed++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            while (!os_tick) @(negedge clk);
        end
    endtask

    task automatic do_reset(input logic [2:0] mode);
        @(negedge clk);
        rst_n = 1'b0; rxd = 1'b1; boot_mode = mode;
        repeat (5) @(negedge clk);
        e_n = 0; w_n = 0;
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] b, input logic stopb);
        rxd = 1'b0; wait_ticks(16);
        for (int i = 0; i < 8; i++) begin rxd = b[i]; wait_ticks(16); end
        rxd = stopb; wait_ticks(16);
        rxd = 1'b1;
    endtask

    task automatic send_field(input logic [23:0] v);
        send_byte(v[7:0], 1'b1);
        send_byte(v[15:8], 1'b1);
        send_byte(v[23:16], 1'b1);
    endtask

    task automatic t_reset_state;
        do_reset(3'b110);
        wait_ticks(40);
        chk(txd == 1'b1, "R10 txd idle", txd, 1);
        chk(run == 1'b0, "R10 run low", run, 0);
        chk(frame_err == 1'b0, "R10 frame_err low", frame_err, 0);
        chk(w_n == 0, "R10 no write", w_n, 0);
    endtask

    task automatic t_full_load;
        logic [23:0] words [0:2];
        logic [7:0]  exp_e [0:14];
        words[0] = 24'h123456; words[1] = 24'hABCDEF; words[2] = 24'h00FF01;
        exp_e = '{8'h03,8'h00,8'h00,8'h10,8'h00,8'h00,8'h56,8'h34,8'h12,
                  8'hEF,8'hCD,8'hAB,8'h01,8'hFF,8'h00};
        do_reset(3'b110);
        send_field(24'h000003);
        send_field(24'h000010);
        chk(run == 1'b0, "R6 no run after header", run, 0);
        for (int k = 0; k < 3; k++) send_field(words[k]);
        wait_ticks(400);
        chk(e_n == 15, "R5 echo count", e_n, 15);
        for (int k = 0; k < 15; k++)
            if (k < e_n) chk(e_log[k] == exp_e[k], "R5 R2 echo byte", e_log[k], exp_e[k]);
        chk(w_n == 3, "R7 write count", w_n, 3);
        for (int k = 0; k < 3; k++) if (k < w_n) begin
            chk(w_addr[k] == 16'h0010 + k, "R7 R6 write address", w_addr[k], 16'h0010 + k);
            chk(w_data[k] == words[k], "R7 word assembly", w_data[k], words[k]);
        end
        chk(run == 1'b1, "R8 run raised", run, 1);
        chk(run_addr == 24'h000010, "R8 run address", run_addr, 24'h10);
        send_byte(8'h77, 1'b1);
        wait_ticks(300);
        chk(e_n == 15, "R8 no echo after run", e_n, 15);
        chk(w_n == 3, "R8 no write after run", w_n, 3);
        chk(run == 1'b1, "R8 run stays", run, 1);
    endtask

    task automatic t_zero_count;
        do_reset(3'b110);
        send_field(24'h000000);
        send_field(24'h0ABCDE);
        wait_ticks(300);
        chk(run == 1'b1, "R9 run after header", run, 1);
        chk(run_addr == 24'h0ABCDE, "R9 run address", run_addr, 24'h0ABCDE);
        chk(w_n == 0, "R9 no write", w_n, 0);
        chk(e_n == 6, "R9 header echoed", e_n, 6);
    endtask

    task automatic t_reserved_mode;
        do_reset(3'b111);
        send_field(24'h000000);
        send_field(24'h000020);
        wait_ticks(300);
        chk(e_n == 0, "R1 no echo in reserved mode", e_n, 0);
        chk(run == 1'b0, "R1 no run in reserved mode", run, 0);
        chk(w_n == 0, "R1 no write in reserved mode", w_n, 0);
    endtask

    task automatic t_glitch;
        do_reset(3'b110);
        rxd = 1'b0; wait_ticks(3); rxd = 1'b1;
        wait_ticks(200);
        chk(e_n == 0, "R3 short start rejected", e_n, 0);
        send_byte(8'hA5, 1'b1);
        wait_ticks(200);
        chk(e_n == 1, "R3 next frame received", e_n, 1);
        if (e_n > 0) chk(e_log[0] == 8'hA5, "R3 R2 byte value", e_log[0], 8'hA5);
    endtask

    task automatic t_frame_err;
        do_reset(3'b110);
        send_byte(8'h5A, 1'b0);
        wait_ticks(200);
        chk(frame_err == 1'b1, "R4 flag set", frame_err, 1);
        chk(e_n == 0, "R4 byte not echoed", e_n, 0);
        // bad byte must not count: a full zero-count header still needs six bytes
        send_field(24'h000000);
        send_field(24'h000042);
        wait_ticks(300);
        chk(run == 1'b1 && run_addr == 24'h000042, "R4 bad byte not counted", run_addr, 24'h42);
        chk(frame_err == 1'b1, "R4 flag sticky", frame_err, 1);
    endtask

    initial begin
        t_reset_state();
        t_full_load();
        t_zero_count();
        t_reserved_mode();
        t_glitch();
        t_frame_err();
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        total++; failed++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end
endmodule